// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by walking three levels of tables in memory. The request carries the access attributes: privilege, instruction fetch, store, probe and debug. The privilege bit picks one of two table base registers. From that base the walker reads a top-level descriptor, then a middle-level descriptor, then a leaf page descriptor. Each read goes through a single 32-bit memory port with a request/acknowledge handshake. The port can also return an error.

While it walks, the block keeps track of write protection from every level. It follows a leaf entry that points to the real descriptor elsewhere, and it writes back the accessed and dirty bits. When the walk ends it produces a single response: a physical address and a permission set, or a fault. A probe request also returns a status word that summarises the walk. The page size is 4 KB or 8 KB, chosen by a control input. Caching of completed translations belongs to a separate block.

Top module: `pt_walker`

## Requirements
- R1: A request with `reqSuper`=1 starts from `rootSuper`, otherwise from `rootUser`. The first read address is (base with bits 8:0 cleared) + 4*addr[31:25]. The second read address is (top descriptor with bits 8:0 cleared) + 4*addr[24:18]. The leaf read address is (middle descriptor with bits 7:0 cleared) + 4*addr[17:12] for 4 KB pages, or (bits 6:0 cleared) + 4*addr[17:13] for 8 KB pages.
- R2: A top or middle descriptor with bit 1 clear is invalid. The walk then ends with `respFault`=1 and no further memory access. A leaf descriptor with bits 1:0 = 00 also faults.
- R3: A top or middle descriptor with the accessed bit (bit 3) clear is written back to its own address with bit 3 set. No write-back happens on any level when `reqDebug`=1.
- R4: Bit 2 set in a descriptor at any level is write protection. It clears the write permission of the result. A store walk faults once a protected descriptor has been seen, and it fetches no deeper level after that.
- R5: A leaf descriptor with bits 1:0 = 10 is indirect. The walker reads the real leaf descriptor from address {desc[31:2],2'b00}, and any write-back goes to that address.
- R6: A store to an unprotected page sets bits 3 and 4 of the leaf descriptor in a write-back if either bit is clear. Every other access sets only bit 3, and only if it is clear. A descriptor that already carries the needed bits is not written.
- R7: `respPhys` is the leaf descriptor with its in-page bits replaced by the logical address offset. The in-page field is bits 11:0 for 4 KB pages (`pageSize8k`=0) and bits 12:0 for 8 KB pages.
- R8: A leaf descriptor with bit 7 set is privileged. A request with `reqSuper`=0 that reaches it faults.
- R9: On a probe, `respStatus` holds the following once a leaf descriptor was reached: leaf physical address bits 31:12 in bits 31:12, leaf descriptor bits 11:5 in bits 11:5, and 1 in bit 0. Bit 2 is set whenever write protection was seen, and all other bits are 0. For a walk that is not a probe, `respStatus` is 0.
- R10: An error response to any read or write-back ends the walk with `respFault`=1.
- R11: `reqReady` is high only while idle, and a request is taken only then. `respValid` is a one-cycle pulse, followed by idle. `memReq`, `memWe` and `memAddr` hold steady until `memAck`.
- R12: `respPerm` is {execute, write, read}. Read is always 1, execute equals the request's fetch flag, and write is 1 only if no write protection was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a translation |
| reqReady | output | 1 | Walker idle, request accepted |
| reqAddr | input | 32 | Logical address |
| reqSuper | input | 1 | Privileged access |
| reqCode | input | 1 | Instruction fetch access |
| reqStore | input | 1 | Store access |
| reqProbe | input | 1 | Probe access, fills status |
| reqDebug | input | 1 | Debug access, no write-back |
| pageSize8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB |
| rootSuper | input | 32 | Privileged table base |
| rootUser | input | 32 | User table base |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Access failed, valid with memAck |
| respValid | output | 1 | Result pulse |
| respFault | output | 1 | Translation failed |
| respPhys | output | 32 | Physical address |
| respPerm | output | 3 | {execute, write, read} |
| respStatus | output | 32 | Probe status word |

## Verification
A wrong walk state or level shows up on `memAddr` at the next memory request. It appears as a read from a table slot the requirements do not predict, or as an extra or missing access. The bench shows these through the write count and the contents of its memory model. A protection flag that was lost or is stuck is seen in `respPerm`, `respFault` or status bit 2 at the response pulse of the same walk. A wrong write-back mask leaves a visibly wrong descriptor in memory as soon as the walk ends.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW         = 32;
  localparam int ROOT_IDX_W = 7;
  localparam int PTR_IDX_W  = 7;
  localparam int OFS_4K     = 12;
  localparam int OFS_8K     = 13;
  localparam int ROOT_LSB   = AW - ROOT_IDX_W;
  localparam int PTR_LSB    = ROOT_LSB - PTR_IDX_W;
  localparam int ALIGN_ROOT = ROOT_IDX_W + 2;
  localparam int ALIGN_PTR  = PTR_IDX_W + 2;
  localparam int ALIGN_PG4  = PTR_LSB - OFS_4K + 2;
  localparam int ALIGN_PG8  = PTR_LSB - OFS_8K + 2;

  localparam int B_WP    = 2;
  localparam int B_USED  = 3;
  localparam int B_MOD   = 4;
  localparam int B_SUPER = 7;

  typedef enum logic [1:0] {LV_ROOT, LV_PTR, LV_PAGE, LV_IND} level_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EVAL, S_WB, S_DONE} state_e;

  typedef struct packed {
    logic start;
    logic capture;
    logic accWp;
    logic markRes;
    logic stepPtr;
    logic stepPage;
    logic stepInd;
    logic setUsed;
    logic setMod;
  } strobe_t;

  typedef struct packed {
    logic upValid;
    logic pgValid;
    logic pgIndirect;
    logic used;
    logic modified;
    logic wp;
    logic superOnly;
    logic wpSeen;
  } decode_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqSuper,
  input  logic          reqCode,
  input  logic          reqProbe,
  input  logic          pageSize8k,
  input  logic [AW-1:0] rootSuper,
  input  logic [AW-1:0] rootUser,
  input  logic [AW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWdata,
  output decode_t       dec,
  output logic [AW-1:0] respPhys,
  output logic [2:0]    respPerm,
  output logic [AW-1:0] respStatus
);
  localparam logic [AW-1:0] M_ROOT = ~((AW'(1) << ALIGN_ROOT) - AW'(1));
  localparam logic [AW-1:0] M_PTR  = ~((AW'(1) << ALIGN_PTR) - AW'(1));
  localparam logic [AW-1:0] M_PG4  = ~((AW'(1) << ALIGN_PG4) - AW'(1));
  localparam logic [AW-1:0] M_PG8  = ~((AW'(1) << ALIGN_PG8) - AW'(1));
  localparam logic [AW-1:0] M_OFS4 = (AW'(1) << OFS_4K) - AW'(1);
  localparam logic [AW-1:0] M_OFS8 = (AW'(1) << OFS_8K) - AW'(1);

  logic [AW-1:0] vaQ, entryQ, descQ;
  logic big8kQ, probeQ, codeQ, wpSeenQ, resQ;
  logic [AW-1:0] rootBase, ofsMask, pageBase;

  assign rootBase = reqSuper ? rootSuper : rootUser;
  assign ofsMask  = big8kQ ? M_OFS8 : M_OFS4;
  assign pageBase = descQ & ~ofsMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; entryQ <= '0; descQ <= '0;
      big8kQ <= 1'b0; probeQ <= 1'b0; codeQ <= 1'b0;
      wpSeenQ <= 1'b0; resQ <= 1'b0;
    end else begin
      if (strb.start) begin
        vaQ     <= reqAddr;
        big8kQ  <= pageSize8k;
        probeQ  <= reqProbe;
        codeQ   <= reqCode;
        wpSeenQ <= 1'b0;
        resQ    <= 1'b0;
        entryQ  <= (rootBase & M_ROOT) | (AW'(reqAddr[AW-1:ROOT_LSB]) << 2);
      end
      if (strb.capture) descQ <= memRdata;
      if (strb.accWp)   wpSeenQ <= wpSeenQ | descQ[B_WP];
      if (strb.markRes) resQ <= 1'b1;
      if (strb.stepPtr)
        entryQ <= (descQ & M_ROOT) | (AW'(vaQ[ROOT_LSB-1:PTR_LSB]) << 2);
      if (strb.stepPage)
        entryQ <= big8kQ ? ((descQ & M_PG8) | (AW'(vaQ[PTR_LSB-1:OFS_8K]) << 2))
                         : ((descQ & M_PG4) | (AW'(vaQ[PTR_LSB-1:OFS_4K]) << 2));
      if (strb.stepInd)
        entryQ <= {descQ[AW-1:2], 2'b00};
    end
  end

  assign memAddr  = entryQ;
  assign memWdata = descQ | (AW'(strb.setUsed) << B_USED) | (AW'(strb.setMod) << B_MOD);

  assign dec.upValid    = descQ[1];
  assign dec.pgValid    = descQ[1:0] != 2'b00;
  assign dec.pgIndirect = descQ[1:0] == 2'b10;
  assign dec.used       = descQ[B_USED];
  assign dec.modified   = descQ[B_MOD];
  assign dec.wp         = descQ[B_WP];
  assign dec.superOnly  = descQ[B_SUPER];
  assign dec.wpSeen     = wpSeenQ;

  assign respPhys = pageBase | (vaQ & ofsMask);
  assign respPerm = {codeQ, ~wpSeenQ, 1'b1};

  always_comb begin
    respStatus = '0;
    if (probeQ) begin
      if (resQ) respStatus = {pageBase[AW-1:12], descQ[11:5], 2'b00, wpSeenQ, 1'b0, 1'b1};
      else      respStatus = AW'(wpSeenQ) << 2;
    end
  end

  // R4: once protection is seen it stays until the next walk starts
  a_r4_wp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wpSeenQ && !strb.start |=> wpSeenQ);
  // R9: resident flag only with a leaf descriptor that was captured
  a_r9_res_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.markRes |-> !strb.start);
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqSuper,
  input  logic    reqStore,
  input  logic    reqDebug,
  input  logic    memAck,
  input  logic    memErr,
  input  decode_t dec,
  output logic    reqReady,
  output logic    memReq,
  output logic    memWe,
  output strobe_t strb,
  output logic    respValid,
  output logic    respFault
);
  state_e stateQ, nState;
  level_e levelQ, nLevel;
  logic faultQ, nFault, superQ, storeQ, debugQ;
  logic wpNow, isPage, wantMod, needWb, doPost;

  assign wpNow   = dec.wpSeen | dec.wp;
  assign isPage  = (levelQ == LV_PAGE) || (levelQ == LV_IND);
  assign wantMod = storeQ && !wpNow;
  assign needWb  = !dec.used || (isPage && wantMod && !dec.modified);

  always_comb begin
    strb   = '0;
    nState = stateQ;
    nLevel = levelQ;
    nFault = faultQ;
    doPost = 1'b0;
    unique case (stateQ)
      S_IDLE: if (reqValid) begin
        strb.start = 1'b1; nState = S_FETCH; nLevel = LV_ROOT; nFault = 1'b0;
      end
      S_FETCH: if (memAck) begin
        if (memErr) begin nFault = 1'b1; nState = S_DONE; end
        else begin strb.capture = 1'b1; nState = S_EVAL; end
      end
      S_EVAL: begin
        if (!isPage) begin
          if (!dec.upValid) begin nFault = 1'b1; nState = S_DONE; end
          else begin
            strb.accWp = 1'b1;
            if (needWb && !debugQ) nState = S_WB; else doPost = 1'b1;
          end
        end else if (levelQ == LV_PAGE && !dec.pgValid) begin
          nFault = 1'b1; nState = S_DONE;
        end else if (levelQ == LV_PAGE && dec.pgIndirect) begin
          strb.stepInd = 1'b1; nLevel = LV_IND; nState = S_FETCH;
        end else begin
          strb.accWp = 1'b1; strb.markRes = 1'b1;
          if (needWb && !debugQ) nState = S_WB; else doPost = 1'b1;
        end
      end
      S_WB: begin
        strb.setUsed = 1'b1;
        strb.setMod  = isPage && wantMod;
        if (memAck) begin
          if (memErr) begin nFault = 1'b1; nState = S_DONE; end
          else doPost = 1'b1;
        end
      end
      S_DONE: nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
    if (doPost) begin
      if (storeQ && wpNow) begin nFault = 1'b1; nState = S_DONE; end
      else if (isPage && dec.superOnly && !superQ) begin nFault = 1'b1; nState = S_DONE; end
      else if (levelQ == LV_ROOT) begin strb.stepPtr = 1'b1; nLevel = LV_PTR; nState = S_FETCH; end
      else if (levelQ == LV_PTR) begin strb.stepPage = 1'b1; nLevel = LV_PAGE; nState = S_FETCH; end
      else nState = S_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE; levelQ <= LV_ROOT; faultQ <= 1'b0;
      superQ <= 1'b0; storeQ <= 1'b0; debugQ <= 1'b0;
    end else begin
      stateQ <= nState; levelQ <= nLevel; faultQ <= nFault;
      if (strb.start) begin
        superQ <= reqSuper; storeQ <= reqStore; debugQ <= reqDebug;
      end
    end
  end

  assign reqReady  = stateQ == S_IDLE;
  assign memReq    = (stateQ == S_FETCH) || (stateQ == S_WB);
  assign memWe     = stateQ == S_WB;
  assign respValid = stateQ == S_DONE;
  assign respFault = faultQ;

  // R3: a debug walk never writes memory
  a_r3_debug_no_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !debugQ);
  // R11: an access waits for its acknowledge
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));
  // R11: response is a single pulse that returns to idle
  a_r11_one_resp: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [31:0]   reqAddr,
  input  logic          reqSuper,
  input  logic          reqCode,
  input  logic          reqStore,
  input  logic          reqProbe,
  input  logic          reqDebug,
  input  logic          pageSize8k,
  input  logic [31:0]   rootSuper,
  input  logic [31:0]   rootUser,
  output logic          memReq,
  output logic          memWe,
  output logic [31:0]   memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  input  logic          memErr,
  output logic          respValid,
  output logic          respFault,
  output logic [31:0]   respPhys,
  output logic [2:0]    respPerm,
  output logic [31:0]   respStatus
);
  strobe_t strb;
  decode_t dec;

  ptw_control u_ctrl (
    .clk, .rstN, .reqValid, .reqSuper, .reqStore, .reqDebug,
    .memAck, .memErr, .dec, .reqReady, .memReq, .memWe,
    .strb, .respValid, .respFault
  );

  ptw_datapath u_dp (
    .clk, .rstN, .strb, .reqAddr, .reqSuper, .reqCode, .reqProbe,
    .pageSize8k, .rootSuper, .rootUser, .memRdata, .memAddr, .memWdata,
    .dec, .respPhys, .respPerm, .respStatus
  );

  // R11: the address stays put while an access is pending
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqSuper = 0, reqCode = 0, reqStore = 0, reqProbe = 0, reqDebug = 0;
  logic pageSize8k = 0;
  logic [31:0] reqAddr = '0, rootSuper = 32'h0001_0000, rootUser = 32'h0002_0000;
  logic reqReady, memReq, memWe, respValid, respFault;
  logic [31:0] memAddr, memWdata, respPhys, respStatus;
  logic [2:0] respPerm;
  logic [31:0] memRdata = '0;
  logic memAck = 0, memErr = 0;

  always #2 clk = ~clk;

  pt_walker u0 (.*);

  logic [31:0] mem [logic [31:0]];
  int wrCount = 0;
  logic errOn = 0;
  logic [31:0] errAddr = '0;
  int nChecks = 0, nFails = 0;
  logic gotFault;
  logic [31:0] gotPhys, gotStatus;
  logic [2:0] gotPerm;
  logic [31:0] rootE, ptrE, pageE;

  localparam logic [31:0] PT = 32'h0003_0000, PG = 32'h0004_0000, VA = 32'h1234_5678;

  always @(negedge clk) begin
    if (memReq && !memAck) begin
      memAck   = 1'b1;
      memErr   = errOn && (memAddr == errAddr);
      memRdata = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      if (memWe && !memErr) begin mem[memAddr] = memWdata; wrCount++; end
    end else begin
      memAck = 1'b0; memErr = 1'b0;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] root, input logic [31:0] va, input logic [31:0] rD,
                       input logic [31:0] pD, input logic [31:0] gD, input logic big);
    rootE = (root & ~32'h1FF) + 4 * va[31:25];
    ptrE  = (rD & ~32'h1FF) + 4 * va[24:18];
    pageE = big ? ((pD & ~32'h7F) + 4 * va[17:13]) : ((pD & ~32'hFF) + 4 * va[17:12]);
    mem[rootE] = rD; mem[ptrE] = pD; mem[pageE] = gD;
  endtask

  task automatic walk(input logic sup, input logic code, input logic st, input logic pr,
                      input logic dbg, input logic [31:0] va, input logic big);
    @(negedge clk);
    reqAddr = va; reqSuper = sup; reqCode = code; reqStore = st; reqProbe = pr;
    reqDebug = dbg; pageSize8k = big; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid) @(negedge clk);
    gotFault = respFault; gotPhys = respPhys; gotPerm = respPerm; gotStatus = respStatus;
  endtask

  task automatic fresh();
    mem.delete(); wrCount = 0; errOn = 0;
  endtask

  task automatic t_reset();
    check("R11 ready after reset", {31'b0, reqReady}, 1);
    check("R11 no resp after reset", {31'b0, respValid}, 0);
    check("R11 no mem req after reset", {31'b0, memReq}, 0);
  endtask

  task automatic t_basic();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C001, 1'b0);
    @(negedge clk);
    reqAddr = VA; reqSuper = 1; reqCode = 0; reqStore = 0; reqProbe = 0; reqDebug = 0;
    pageSize8k = 0; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check("R11 busy after accept", {31'b0, reqReady}, 0);
    while (!respValid) @(negedge clk);
    check("R1 fault", {31'b0, respFault}, 0);
    check("R7 phys 4K", respPhys, 32'h00AB_C678);
    check("R12 perm read", {29'b0, respPerm}, 3'b011);
    check("R9 status without probe", respStatus, 0);
    @(negedge clk);
    check("R11 single pulse", {31'b0, respValid}, 0);
    check("R3 top used", rd(rootE), PT | 32'hA);
    check("R3 mid used", rd(ptrE), PG | 32'hA);
    check("R6 leaf used only", rd(pageE), 32'h00AB_C009);
    check("R6 write count", wrCount, 3);
    fresh();
    build(rootSuper, VA, PT | 32'hA, PG | 32'hA, 32'h00AB_C009, 1'b0);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R6 no write when bits set", wrCount, 0);
  endtask

  task automatic t_user();
    fresh();
    build(rootUser, VA, PT | 32'h2, PG | 32'h2, 32'h00DE_F001, 1'b0);
    walk(0, 0, 0, 0, 0, VA, 0);
    check("R1 user root fault", {31'b0, gotFault}, 0);
    check("R1 user root phys", gotPhys, 32'h00DE_F678);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R1 super root empty faults", {31'b0, gotFault}, 1);
  endtask

  task automatic t_store();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C001, 1'b0);
    walk(1, 0, 1, 0, 0, VA, 0);
    check("R6 store ok", {31'b0, gotFault}, 0);
    check("R6 leaf used+mod", rd(pageE), 32'h00AB_C019);
  endtask

  task automatic t_wp();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h6, 32'h00AB_C001, 1'b0);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R4 read through wp ok", {31'b0, gotFault}, 0);
    check("R12 write cleared", {29'b0, gotPerm}, 3'b001);
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h6, 32'h00AB_C001, 1'b0);
    walk(1, 0, 1, 0, 0, VA, 0);
    check("R4 store faults", {31'b0, gotFault}, 1);
    check("R4 mid written back first", rd(ptrE), PG | 32'hE);
    check("R4 leaf untouched", rd(pageE), 32'h00AB_C001);
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C005, 1'b0);
    walk(1, 0, 1, 0, 0, VA, 0);
    check("R4 leaf wp store faults", {31'b0, gotFault}, 1);
    check("R6 wp leaf used only", rd(pageE), 32'h00AB_C00D);
  endtask

  task automatic t_invalid();
    fresh();
    build(rootSuper, VA, PT | 32'h1, PG | 32'h2, 32'h00AB_C001, 1'b0);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R2 top invalid fault", {31'b0, gotFault}, 1);
    check("R2 no write", wrCount, 0);
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C000, 1'b0);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R2 leaf invalid fault", {31'b0, gotFault}, 1);
  endtask

  task automatic t_indirect();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h0005_0002, 1'b0);
    mem[32'h0005_0000] = 32'h0077_7001;
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R5 indirect fault", {31'b0, gotFault}, 0);
    check("R5 indirect phys", gotPhys, 32'h0077_7678);
    check("R5 target written", rd(32'h0005_0000), 32'h0077_7009);
    check("R5 pointer unchanged", rd(pageE), 32'h0005_0002);
  endtask

  task automatic t_8k();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_D001, 1'b1);
    walk(1, 0, 0, 0, 0, VA, 1);
    check("R7 8K fault", {31'b0, gotFault}, 0);
    check("R7 phys 8K", gotPhys, 32'h00AB_D678);
    check("R7 8K leaf written", rd(pageE), 32'h00AB_D009);
  endtask

  task automatic t_super();
    fresh();
    build(rootUser, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C081, 1'b0);
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C081, 1'b0);
    walk(0, 0, 0, 0, 0, VA, 0);
    check("R8 user on privileged page", {31'b0, gotFault}, 1);
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R8 privileged ok", {31'b0, gotFault}, 0);
  endtask

  task automatic t_debug();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C001, 1'b0);
    walk(1, 0, 1, 0, 1, VA, 0);
    check("R3 debug ok", {31'b0, gotFault}, 0);
    check("R3 debug no writes", wrCount, 0);
    check("R6 debug leaf unchanged", rd(pageE), 32'h00AB_C001);
  endtask

  task automatic t_probe();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h6, 32'h00AB_C461, 1'b0);
    walk(1, 0, 0, 1, 0, VA, 0);
    check("R9 probe status", gotStatus, 32'h00AB_C465);
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C461, 1'b0);
    walk(1, 0, 0, 1, 0, VA, 0);
    check("R9 probe status no wp", gotStatus, 32'h00AB_C461);
  endtask

  task automatic t_memerr();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C001, 1'b0);
    errOn = 1; errAddr = ptrE;
    walk(1, 0, 0, 0, 0, VA, 0);
    check("R10 read error faults", {31'b0, gotFault}, 1);
    check("R10 leaf untouched", rd(pageE), 32'h00AB_C001);
    errOn = 0;
  endtask

  task automatic t_code();
    fresh();
    build(rootSuper, VA, PT | 32'h2, PG | 32'h2, 32'h00AB_C001, 1'b0);
    walk(1, 1, 0, 0, 0, VA, 0);
    check("R12 fetch perm", {29'b0, gotPerm}, 3'b111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_user();
    t_store();
    t_wp();
    t_invalid();
    t_indirect();
    t_8k();
    t_super();
    t_debug();
    t_probe();
    t_memerr();
    t_code();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule